// File: doc/BRIEF.md
# Supply-Fail Reset Pulse Generator

This block produces the reset that a processor sees. It has two sources. The first is a supply-good level that has already been synchronized. The second is a single-cycle expiry request from a watchdog. When the supply is reported bad, reset becomes active on the next clock edge, whether or not an oscillator tick is present.

Once the supply is good again, reset stays active for a set number of oscillator ticks before it releases. The tick is a single-cycle enable from a slow oscillator. A watchdog expiry that arrives while reset is inactive starts a reset pulse of the same length.

A static strap chooses between a short width and a long width. The defaults are 512 and 2048 ticks, which give 50 ms and 200 ms at a 10.24 kHz tick. Reset is driven as an active-low output and as its active-high complement. A one-clock strobe marks the end of every reset so that the watchdog can restart its timeout. The strobe fires whatever caused the reset.

Top module: `supfail_rst_gen`

## Requirements
- R1: While `supply_ok` is 0 at a rising clock edge, `rst_n_out` is 0 after that edge, regardless of `tick_en`.
- R2: With `width_long` = 0, reset releases (`rst_n_out` goes to 1) on the edge of the SHORT_TICKS-th cycle with `tick_en` = 1 and `supply_ok` = 1 that follows the start of the stretch. Cycles with `tick_en` = 0 do not advance the count.
- R3: With `width_long` = 1, the same release happens on the LONG_TICKS-th counted tick.
- R4: A `wdog_expire` pulse while `rst_n_out` = 1 makes `rst_n_out` 0 after the next edge. It starts a stretch of the width selected by the strap.
- R5: `rst_out` is always the complement of `rst_n_out`.
- R6: `wdog_restart` is 1 for exactly one clock: the first cycle in which `rst_n_out` is 1 after being 0. It is 0 at all other times.
- R7: If `supply_ok` drops during a stretch, the tick count restarts from zero. A full width of ticks is needed after `supply_ok` returns.
- R8: `por_n` = 0 forces `rst_n_out` = 0, `rst_out` = 1 and `wdog_restart` = 0 at once, without a clock. It also clears the tick count, so the first release after `por_n` rises needs a full width of ticks.
- R9: A `wdog_expire` pulse while `rst_n_out` = 0 has no effect. The release happens on the same tick as if the pulse had not occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick_en | input | 1 | Single-cycle oscillator tick enable |
| supply_ok | input | 1 | Synchronized supply-good level, 1 = supply valid |
| wdog_expire | input | 1 | Single-cycle watchdog expiry request |
| width_long | input | 1 | Static strap: 0 = short width, 1 = long width |
| rst_n_out | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |
| wdog_restart | output | 1 | One-clock strobe at the end of every reset |

## Verification
The bench builds the block with SHORT_TICKS = 4 and LONG_TICKS = 10. At these values every release edge is only a few cycles away. The bench can therefore hit the exact tick on which reset releases, and the tick just before it, for both strap settings. Cycles with no tick, supply drops during a stretch and watchdog requests that arrive during an active reset are placed between counted ticks. This shows that each one either reloads the count or leaves it alone.

// File: rtl/supfail_pkg.sv
package supfail_pkg;
   // Controller state: running with reset released, or holding reset
   typedef enum logic {
      ST_RUN  = 1'b0,
      ST_HOLD = 1'b1
   } rst_state_e;
endpackage

// File: rtl/supfail_width_sel.sv
module supfail_width_sel #(
   parameter int SHORT_TICKS = 512,
   parameter int LONG_TICKS  = 2048,
   parameter bit STRAP_EN    = 1'b1,
   parameter int CW          = 11
) (
   input  logic          width_long,
   output logic [CW-1:0] last_idx
);
   localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
   localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

   generate
      if (STRAP_EN) begin : g_strap
         assign last_idx = width_long ? LONG_LAST : SHORT_LAST;
      end else begin : g_fixed
         logic unused_strap;
         assign unused_strap = width_long;
         assign last_idx     = SHORT_LAST;
      end
   endgenerate
endmodule

// File: rtl/supfail_tick_cnt.sv
module supfail_tick_cnt #(
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          clr,
   input  logic          inc,
   input  logic [CW-1:0] last_idx,
   output logic          at_last
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign at_last = (cnt_q == last_idx);
endmodule

// File: rtl/supfail_ctrl.sv
module supfail_ctrl
   import supfail_pkg::*;
(
   input  logic clk,
   input  logic por_n,
   input  logic supply_ok,
   input  logic wdog_expire,
   input  logic tick_en,
   input  logic at_last,
   output logic cnt_clr,
   output logic cnt_inc,
   output logic rst_active,
   output logic restart
);
   rst_state_e state_q, state_d;
   logic       restart_q, restart_d;
   logic       done;

   // A stretch ends on the counted tick that reaches the last index
   assign done = (state_q == ST_HOLD) && supply_ok && tick_en && at_last;

   always_comb begin
      state_d   = state_q;
      restart_d = 1'b0;
      if (!supply_ok) begin
         state_d = ST_HOLD;
      end else if (state_q == ST_HOLD) begin
         if (done) begin
            state_d   = ST_RUN;
            restart_d = 1'b1;
         end
      end else if (wdog_expire) begin
         state_d = ST_HOLD;
      end
   end

   // Counter sits at zero unless a stretch is counting with supply good
   assign cnt_clr = !supply_ok || (state_q == ST_RUN);
   assign cnt_inc = (state_q == ST_HOLD) && supply_ok && tick_en && !at_last;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q   <= ST_HOLD;
         restart_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         restart_q <= restart_d;
      end
   end

   assign rst_active = (state_q == ST_HOLD);
   assign restart    = restart_q;
endmodule

// File: rtl/supfail_rst_gen.sv
module supfail_rst_gen #(
   parameter int SHORT_TICKS = 512,
   parameter int LONG_TICKS  = 2048,
   parameter bit STRAP_EN    = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic tick_en,
   input  logic supply_ok,
   input  logic wdog_expire,
   input  logic width_long,
   output logic rst_n_out,
   output logic rst_out,
   output logic wdog_restart
);
   localparam int CW = (LONG_TICKS > 2) ? $clog2(LONG_TICKS) : 1;

   generate
      if (SHORT_TICKS < 1) begin : g_bad_short
         $error("SHORT_TICKS must be at least 1");
      end
      if (LONG_TICKS < SHORT_TICKS) begin : g_bad_long
         $error("LONG_TICKS must not be below SHORT_TICKS");
      end
   endgenerate

   logic [CW-1:0] last_idx;
   logic          at_last;
   logic          cnt_clr;
   logic          cnt_inc;
   logic          rst_active;

   supfail_width_sel #(
      .SHORT_TICKS (SHORT_TICKS),
      .LONG_TICKS  (LONG_TICKS),
      .STRAP_EN    (STRAP_EN),
      .CW          (CW)
   ) u_wsel (
      .width_long (width_long),
      .last_idx   (last_idx)
   );

   supfail_tick_cnt #(
      .CW (CW)
   ) u_cnt (
      .clk      (clk),
      .por_n    (por_n),
      .clr      (cnt_clr),
      .inc      (cnt_inc),
      .last_idx (last_idx),
      .at_last  (at_last)
   );

   supfail_ctrl u_ctrl (
      .clk         (clk),
      .por_n       (por_n),
      .supply_ok   (supply_ok),
      .wdog_expire (wdog_expire),
      .tick_en     (tick_en),
      .at_last     (at_last),
      .cnt_clr     (cnt_clr),
      .cnt_inc     (cnt_inc),
      .rst_active  (rst_active),
      .restart     (wdog_restart)
   );

   assign rst_n_out = !rst_active;
   assign rst_out   = rst_active;
endmodule

// File: rtl/supfail_rst_gen_chk.sv
module supfail_rst_gen_chk (
   input logic clk,
   input logic por_n,
   input logic tick_en,
   input logic supply_ok,
   input logic wdog_expire,
   input logic rst_n_out,
   input logic rst_out,
   input logic wdog_restart
);
   // R1
   supply_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
      !supply_ok |=> !rst_n_out);

   // R2
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_n_out && !tick_en) |=> !rst_n_out);

   // R4
   wdog_fire_chk: assert property (@(posedge clk) disable iff (!por_n)
      (rst_n_out && wdog_expire) |=> !rst_n_out);

   // R5
   complement_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_out != rst_n_out);

   // R6
   restart_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_n_out) |-> wdog_restart);

   // R6
   restart_only_chk: assert property (@(posedge clk) disable iff (!por_n)
      wdog_restart |-> $rose(rst_n_out));
endmodule

bind supfail_rst_gen supfail_rst_gen_chk u_chk (
   .clk          (clk),
   .por_n        (por_n),
   .tick_en      (tick_en),
   .supply_ok    (supply_ok),
   .wdog_expire  (wdog_expire),
   .rst_n_out    (rst_n_out),
   .rst_out      (rst_out),
   .wdog_restart (wdog_restart)
);

// File: tb/sim_supfail_rst_gen.sv
`timescale 1ns/1ps
module sim_supfail_rst_gen;
   localparam int SHORT = 4;
   localparam int LONG  = 10;
   localparam int NVEC  = 21;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic tick_en = 1'b0;
   logic supply_ok = 1'b1;
   logic wdog_expire = 1'b0;
   logic width_long = 1'b0;
   logic rst_n_out, rst_out, wdog_restart;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   supfail_rst_gen #(
      .SHORT_TICKS (SHORT),
      .LONG_TICKS  (LONG),
      .STRAP_EN    (1'b1)
   ) u0 (
      .clk          (clk),
      .por_n        (por_n),
      .tick_en      (tick_en),
      .supply_ok    (supply_ok),
      .wdog_expire  (wdog_expire),
      .width_long   (width_long),
      .rst_n_out    (rst_n_out),
      .rst_out      (rst_out),
      .wdog_restart (wdog_restart)
   );

   // {tick, supply_ok, wdog, expected rst_n, expected restart}, short width
   localparam logic [4:0] VEC [NVEC] = '{
      5'b11_0_0_0, 5'b11_0_0_0, 5'b01_0_0_0, 5'b11_0_0_0, 5'b11_0_1_1,  // R2 R6
      5'b01_0_1_0, 5'b01_1_0_0,                                          // R4
      5'b11_0_0_0, 5'b11_1_0_0, 5'b11_0_0_0, 5'b11_0_1_1, 5'b11_0_1_0,  // R9
      5'b00_0_0_0,                                                       // R1
      5'b11_0_0_0, 5'b11_0_0_0, 5'b10_0_0_0,                             // R7
      5'b11_0_0_0, 5'b11_0_0_0, 5'b11_0_0_0, 5'b11_0_1_1, 5'b01_0_1_0   // R7
   };

   task automatic check(input string req, input logic exp_n, input logic exp_s);
      n_run++;
      if (rst_n_out !== exp_n || rst_out !== !exp_n || wdog_restart !== exp_s) begin
         n_fail++;
         $display("FAIL %s: rst_n=%b rst=%b restart=%b expected rst_n=%b rst=%b restart=%b",
                  req, rst_n_out, rst_out, wdog_restart, exp_n, !exp_n, exp_s);
      end
   endtask

   task automatic cyc(input logic t, input logic ok, input logic wd);
      tick_en = t; supply_ok = ok; wdog_expire = wd;
      @(posedge clk); #1;
   endtask

   initial begin
      // R8 reset state
      #9;
      check("R8 por state", 1'b0, 1'b0);
      @(posedge clk); #1;
      por_n = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         cyc(VEC[i][4], VEC[i][3], VEC[i][2]);
         check($sformatf("R5 vec%0d", i), VEC[i][1], VEC[i][0]);
      end
      // R3 long width after a watchdog pulse
      width_long = 1'b1;
      cyc(1'b0, 1'b1, 1'b1);
      check("R4 long start", 1'b0, 1'b0);
      for (int k = 0; k < LONG - 1; k++) cyc(1'b1, 1'b1, 1'b0);
      check("R3 before last tick", 1'b0, 1'b0);
      cyc(1'b1, 1'b1, 1'b0);
      check("R3 release", 1'b1, 1'b1);
      cyc(1'b0, 1'b1, 1'b0);
      check("R6 strobe single", 1'b1, 1'b0);
      // R8 async power-on reset mid-stretch
      width_long = 1'b0;
      cyc(1'b0, 1'b1, 1'b1);
      cyc(1'b1, 1'b1, 1'b0);
      cyc(1'b1, 1'b1, 1'b0);
      #1 por_n = 1'b0;
      #0.5;
      check("R8 async assert", 1'b0, 1'b0);
      @(posedge clk); #1;
      por_n = 1'b1;
      for (int k = 0; k < SHORT - 1; k++) cyc(1'b1, 1'b1, 1'b0);
      check("R8 count cleared", 1'b0, 1'b0);
      cyc(1'b1, 1'b1, 1'b0);
      check("R8 release", 1'b1, 1'b1);
      // R1 drop with no tick while released
      cyc(1'b0, 1'b0, 1'b0);
      check("R1 immediate", 1'b0, 1'b0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule